// File: doc/BRIEF.md
# Byte ALU with Flag Byte

This block computes one of seven byte operations on two 8-bit operands in the same cycle: plain add, add with carry, plain subtract, subtract with borrow, AND, OR and XOR. Along with the 8-bit result it produces a flag byte. The flag byte carries sign, zero, half-carry, parity/overflow, subtract and carry indications, each at a fixed bit position that downstream logic decodes.

The flag byte is combinational. It can be captured into an internal flag register on a rising clock edge by raising a write enable. The stored carry bit of that register feeds the carry-in of the add-with-carry and subtract-with-borrow operations. This lets a multi-byte add or subtract be chained one byte at a time: each step writes its flags and the next step consumes the stored carry.

Top module: `byte_alu`

## Requirements
- R1: `opSel` selects the operation: 0 add, 1 add with carry, 2 subtract (A minus B), 3 subtract with borrow, 4 AND, 5 OR, 6 XOR, and 7 behaves exactly as 6. `result` is the low 8 bits of the operation.
- R2: Codes 1 and 3 add, or subtract, the stored flag register bit 0 as carry-in or borrow-in. Codes 0 and 2 ignore that bit.
- R3: Flag bit 7 equals `result` bit 7.
- R4: Flag bit 6 is 1 exactly when `result` is 0x00.
- R5: Flag bit 4 is the carry out of bit 3 for codes 0 and 1, and the borrow into bit 4 for codes 2 and 3. It is 1 for AND and 0 for OR and XOR.
- R6: Flag bit 2 is two's-complement signed overflow for codes 0 to 3. For codes 4 to 7 it is 1 when `result` has an even number of ones.
- R7: Flag bit 1 is 1 for codes 2 and 3 and 0 for all other codes.
- R8: Flag bit 0 is the carry out of bit 7 for codes 0 and 1, the borrow for codes 2 and 3, and 0 for codes 4 to 7.
- R9: Flag bits 5 and 3 are always 0, both in `flagsNow` and in `flagReg`.
- R10: `flagReg` takes the value of `flagsNow` on a rising edge of `clk` while `flagWrEn` is 1. Otherwise it holds its value. An active-low `rstN` clears it asynchronously to 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rstN | input | 1 | Asynchronous active-low reset |
| opA | input | 8 | First operand |
| opB | input | 8 | Second operand (subtrahend) |
| opSel | input | 3 | Operation code |
| flagWrEn | input | 1 | Load flag register on next rising edge |
| result | output | 8 | Operation result |
| flagsNow | output | 8 | Flag byte of the current operation |
| flagReg | output | 8 | Stored flag byte |

## Verification
On every cycle the assertions check the relations that can be read from the outputs alone:
- sign and zero against `result`;
- the subtract flag against the operation class;
- the cleared carry and subtract flags for logical operations;
- parity for logical operations;
- the zero spare bits;
- load and hold of the flag register.

The arithmetic flags (half-carry, signed overflow, carry and borrow) depend on the operands in ways only the bench's reference model shows. The bench covers them with directed operand pairs: nibble-boundary cases, wrap-around, signed overflow in both directions and zero results. Carry chaining through the stored flag register is also shown only by bench scenarios.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int OP_W   = 3;

  // flag byte bit positions, decoded by neighbouring logic
  localparam int FLG_SIGN = 7;
  localparam int FLG_ZERO = 6;
  localparam int FLG_HALF = 4;
  localparam int FLG_PV   = 2;
  localparam int FLG_SUB  = 1;
  localparam int FLG_CRY  = 0;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 3'd0,
    OP_ADC  = 3'd1,
    OP_SUB  = 3'd2,
    OP_SBC  = 3'd3,
    OP_AND  = 3'd4,
    OP_OR   = 3'd5,
    OP_XOR  = 3'd6,
    OP_XOR2 = 3'd7
  } aluOp_e;

  typedef enum logic [1:0] {
    LF_AND = 2'd0,
    LF_OR  = 2'd1,
    LF_XOR = 2'd2
  } logicFn_e;

  typedef struct packed {
    logic     subMode;
    logic     carryUse;
    logic     logicMode;
    logicFn_e logicFn;
  } aluStrobes_t;
endpackage

// File: rtl/byte_alu_ctrl.sv
module byte_alu_ctrl
  import byte_alu_pkg::*;
(
  input  logic [OP_W-1:0] opSel,
  output aluStrobes_t     strobes
);
  always_comb begin
    strobes = '{subMode: 1'b0, carryUse: 1'b0, logicMode: 1'b0, logicFn: LF_AND};
    unique case (aluOp_e'(opSel))
      OP_ADD:  ;
      OP_ADC:  strobes.carryUse = 1'b1;
      OP_SUB:  strobes.subMode  = 1'b1;
      OP_SBC: begin
        strobes.subMode  = 1'b1;
        strobes.carryUse = 1'b1;
      end
      OP_AND: strobes.logicMode = 1'b1;
      OP_OR: begin
        strobes.logicMode = 1'b1;
        strobes.logicFn   = LF_OR;
      end
      OP_XOR, OP_XOR2: begin
        strobes.logicMode = 1'b1;
        strobes.logicFn   = LF_XOR;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/byte_alu_dp.sv
module byte_alu_dp
  import byte_alu_pkg::*;
(
  input  aluStrobes_t       strobes,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              storedCarry,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] flagsNow
);
  logic [DATA_W-1:0] bOperand;
  logic              cinEff;
  logic [DATA_W:0]   fullSum;
  logic [NIB_W:0]    nibSum;
  logic [DATA_W-1:0] arithRes;
  logic [DATA_W-1:0] logicRes;
  logic              arithCarry;
  logic              arithHalf;
  logic              arithOvf;
  logic              halfBit;
  logic              pvBit;
  logic              cryBit;

  // subtraction as A + ~B + ~borrow; raw carries are inverted back to borrows
  always_comb begin
    bOperand = strobes.subMode ? ~opB : opB;
    cinEff   = (strobes.carryUse & storedCarry) ^ strobes.subMode;
    fullSum  = {1'b0, opA} + {1'b0, bOperand} + {{DATA_W{1'b0}}, cinEff};
    nibSum   = {1'b0, opA[NIB_W-1:0]} + {1'b0, bOperand[NIB_W-1:0]}
               + {{NIB_W{1'b0}}, cinEff};
    arithRes   = fullSum[DATA_W-1:0];
    arithCarry = fullSum[DATA_W] ^ strobes.subMode;
    arithHalf  = nibSum[NIB_W] ^ strobes.subMode;
    arithOvf   = (opA[DATA_W-1] == bOperand[DATA_W-1])
                 && (arithRes[DATA_W-1] != opA[DATA_W-1]);
  end

  always_comb begin
    unique case (strobes.logicFn)
      LF_AND:  logicRes = opA & opB;
      LF_OR:   logicRes = opA | opB;
      default: logicRes = opA ^ opB;
    endcase
  end

  always_comb begin
    if (strobes.logicMode) begin
      result  = logicRes;
      halfBit = (strobes.logicFn == LF_AND);
      pvBit   = ~^logicRes;
      cryBit  = 1'b0;
    end else begin
      result  = arithRes;
      halfBit = arithHalf;
      pvBit   = arithOvf;
      cryBit  = arithCarry;
    end
  end

  always_comb begin
    flagsNow           = '0;
    flagsNow[FLG_SIGN] = result[DATA_W-1];
    flagsNow[FLG_ZERO] = (result == '0);
    flagsNow[FLG_HALF] = halfBit;
    flagsNow[FLG_PV]   = pvBit;
    flagsNow[FLG_SUB]  = strobes.subMode & ~strobes.logicMode;
    flagsNow[FLG_CRY]  = cryBit;
  end
endmodule

// File: rtl/byte_alu_freg.sv
module byte_alu_freg
  import byte_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] flagsIn,
  output logic [DATA_W-1:0] flagsOut
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     flagsOut <= '0;
    else if (wrEn) flagsOut <= flagsIn;
  end
endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [OP_W-1:0]   opSel,
  input  logic              flagWrEn,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] flagsNow,
  output logic [DATA_W-1:0] flagReg
);
  aluStrobes_t strobes;

  byte_alu_ctrl u_ctrl (
    .opSel   (opSel),
    .strobes (strobes)
  );

  byte_alu_dp u_dp (
    .strobes     (strobes),
    .opA         (opA),
    .opB         (opB),
    .storedCarry (flagReg[FLG_CRY]),
    .result      (result),
    .flagsNow    (flagsNow)
  );

  byte_alu_freg u_freg (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (flagWrEn),
    .flagsIn  (flagsNow),
    .flagsOut (flagReg)
  );
endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] opSel,
  input logic       flagWrEn,
  input logic [7:0] result,
  input logic [7:0] flagsNow,
  input logic [7:0] flagReg
);
  assert_sign_R3: assert property (@(posedge clk) disable iff (!rstN)
    flagsNow[7] == result[7]);

  assert_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    flagsNow[6] == (result == 8'h00));

  assert_logic_parity_R6: assert property (@(posedge clk) disable iff (!rstN)
    opSel[2] |-> (flagsNow[2] == ~^result));

  assert_sub_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    flagsNow[1] == (opSel[2:1] == 2'b01));

  assert_logic_no_carry_R8: assert property (@(posedge clk) disable iff (!rstN)
    opSel[2] |-> (flagsNow[0] == 1'b0));

  assert_spare_bits_R9: assert property (@(posedge clk) disable iff (!rstN)
    (flagsNow[5] == 1'b0) && (flagsNow[3] == 1'b0)
    && (flagReg[5] == 1'b0) && (flagReg[3] == 1'b0));

  assert_flag_load_R10: assert property (@(posedge clk) disable iff (!rstN)
    flagWrEn |=> (flagReg == $past(flagsNow)));

  assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !flagWrEn |=> $stable(flagReg));
endmodule

bind byte_alu byte_alu_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .opSel    (opSel),
  .flagWrEn (flagWrEn),
  .result   (result),
  .flagsNow (flagsNow),
  .flagReg  (flagReg)
);

// File: tb/byte_alu_bench.sv
module byte_alu_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] opA = '0;
  logic [7:0] opB = '0;
  logic [2:0] opSel = '0;
  logic       flagWrEn = 1'b0;
  logic [7:0] result;
  logic [7:0] flagsNow;
  logic [7:0] flagReg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] modelReg = 8'h00;

  always #4 clk = ~clk;

  byte_alu u_byte_alu (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .opSel(opSel),
    .flagWrEn(flagWrEn), .result(result), .flagsNow(flagsNow), .flagReg(flagReg)
  );

  // reference model from the requirements: returns {result, flags}
  function automatic logic [15:0] refModel(input logic [7:0] a, input logic [7:0] b,
                                           input logic [2:0] op, input logic cin);
    int ai, bi, ci, full, low, sa, sb, sr;
    logic [7:0] r;
    logic s, z, h, p, n, c;
    ai = a; bi = b; sa = $signed(a); sb = $signed(b);
    ci = (op == 3'd1 || op == 3'd3) ? int'(cin) : 0;
    n = 1'b0;
    if (op <= 3'd1) begin
      full = ai + bi + ci;
      low  = (ai % 16) + (bi % 16) + ci;
      sr   = sa + sb + ci;
      r = full[7:0]; c = (full > 255); h = (low > 15);
      p = (sr > 127) || (sr < -128);
    end else if (op <= 3'd3) begin
      full = ai - bi - ci;
      low  = (ai % 16) - (bi % 16) - ci;
      sr   = sa - sb - ci;
      r = full[7:0]; c = (full < 0); h = (low < 0); n = 1'b1;
      p = (sr > 127) || (sr < -128);
    end else begin
      if (op == 3'd4)      begin r = a & b; h = 1'b1; end
      else if (op == 3'd5) begin r = a | b; h = 1'b0; end
      else                 begin r = a ^ b; h = 1'b0; end
      c = 1'b0;
      p = ($countones(r) % 2) == 0;
    end
    s = r[7];
    z = (r == 8'h00);
    return {r, s, z, 1'b0, h, 1'b0, p, n, c};
  endfunction

  task automatic expect8(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  // apply an operation at the falling edge, compare the combinational outputs
  task automatic checkOp(input string req, input logic [7:0] a, input logic [7:0] b,
                         input logic [2:0] op);
    logic [15:0] exp;
    @(negedge clk);
    opA = a; opB = b; opSel = op;
    #1;
    exp = refModel(a, b, op, modelReg[0]);
    expect8(req, "result", result, exp[15:8]);
    expect8(req, "flags", flagsNow, exp[7:0]);
  endtask

  // capture the current flags and confirm the stored value after the edge
  task automatic writeFlags(input string req);
    logic [7:0] snap;
    snap = refModel(opA, opB, opSel, modelReg[0]) & 8'hFF;
    flagWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    flagWrEn = 1'b0;
    modelReg = snap;
    expect8(req, "flagReg", flagReg, modelReg);
  endtask

  task automatic tResetState();
    expect8("R10", "reset flagReg", flagReg, 8'h00);
  endtask

  task automatic tAdd();
    checkOp("R1", 8'h12, 8'h34, 3'd0);
    checkOp("R5", 8'h0F, 8'h01, 3'd0);   // half carry
    checkOp("R8", 8'hFF, 8'h01, 3'd0);   // wrap to zero, carry (R4)
    checkOp("R6", 8'h7F, 8'h01, 3'd0);   // positive overflow, sign (R3)
    checkOp("R6", 8'h80, 8'h80, 3'd0);   // negative overflow
  endtask

  task automatic tCarryChain();
    checkOp("R8", 8'hF0, 8'h20, 3'd0);   // sets carry
    writeFlags("R10");
    checkOp("R2", 8'h00, 8'h00, 3'd1);   // ADC consumes stored carry -> 01
    checkOp("R2", 8'h0F, 8'h00, 3'd1);   // carry-in makes half carry
    checkOp("R2", 8'h05, 8'h03, 3'd0);   // ADD ignores stored carry
    checkOp("R2", 8'h05, 8'h03, 3'd2);   // SUB ignores stored borrow
    checkOp("R2", 8'h05, 8'h03, 3'd3);   // SBC uses it -> 01
    checkOp("R2", 8'h00, 8'h00, 3'd3);   // borrow through zero -> FF
  endtask

  task automatic tSub();
    checkOp("R7", 8'h50, 8'h20, 3'd2);
    checkOp("R4", 8'h42, 8'h42, 3'd2);   // zero result
    checkOp("R5", 8'h10, 8'h01, 3'd2);   // nibble borrow
    checkOp("R8", 8'h01, 8'h02, 3'd2);   // borrow, result FF
    checkOp("R6", 8'h80, 8'h01, 3'd2);   // signed overflow
    checkOp("R6", 8'h7F, 8'hFF, 3'd2);   // signed overflow other way
  endtask

  task automatic tLogic();
    checkOp("R5", 8'hF0, 8'h3C, 3'd4);   // AND sets half
    checkOp("R4", 8'hF0, 8'h0F, 3'd4);   // AND to zero
    checkOp("R6", 8'h01, 8'h02, 3'd5);   // OR, even parity
    checkOp("R6", 8'h01, 8'h00, 3'd5);   // OR, odd parity
    checkOp("R1", 8'hAA, 8'hFF, 3'd6);   // XOR
    checkOp("R1", 8'hAA, 8'hFF, 3'd7);   // code 7 as XOR
    checkOp("R9", 8'hFF, 8'hFF, 3'd6);
  endtask

  task automatic tFlagHold();
    logic [7:0] held;
    checkOp("R8", 8'hFF, 8'h01, 3'd0);
    writeFlags("R10");
    held = modelReg;
    checkOp("R10", 8'h01, 8'h01, 3'd4);
    @(posedge clk);
    @(negedge clk);
    expect8("R10", "hold without enable", flagReg, held);
    writeFlags("R9");
    rstN = 1'b0;
    #1;
    modelReg = 8'h00;
    expect8("R10", "async reset", flagReg, 8'h00);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tResetState();
    rstN = 1'b1;
    tAdd();
    tCarryChain();
    tSub();
    tLogic();
    tFlagHold();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule